// File: doc/BRIEF.md
# Accumulator Operate Micro-Op Unit

This unit executes the register-only "operate" group of a 12-bit accumulator machine that also carries a one-bit link register. An instruction supplies a 9-bit operate field. Each set bit in that field enables one micro-operation: clear, complement, increment, rotate or half-word swap. The unit applies all the enabled micro-operations to the accumulator and the link in a fixed sequence within a single instruction. It registers the outcome one clock later.

A pipeline feeds it a valid strobe, the field and the present accumulator and link values. It returns the new accumulator and link with a result-valid strobe. It also returns four flags that tell the surrounding hazard logic which of the two registers the instruction consumed and which it produced. Fields whose top bit is set belong to a different instruction group and are not accepted.

Top module: `acc_opr_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and link outputs, all four register-use flags and the result-valid strobe.
- R2: A field is accepted only when `vld_i` is 1 and field bit 8 (octal 0400) is 0. Its results appear on the outputs one clock later, with `res_vld_o` at 1. In any other cycle, every data and flag output holds its value and `res_vld_o` is 0.
- R3: The first step applies bit 7 (0200), which clears the accumulator, and bit 6 (0100), which clears the link.
- R4: Next, bit 5 (0040) inverts every accumulator bit and bit 4 (0020) inverts the link.
- R5: After that, bit 0 (0001) adds one to the 12-bit accumulator. When the sum wraps to zero, the link is inverted; it is not forced to 1.
- R6: After the increment, bit 3 (0010) rotates the 13-bit value {link, accumulator} right by one, so accumulator bit 0 enters the link and the link enters accumulator bit 11. Bit 2 (0004) rotates it left by one, so the link enters accumulator bit 0 and accumulator bit 11 enters the link.
- R7: When bit 1 (0002) is set together with exactly one rotate bit, that rotate is done twice.
- R8: When bit 1 is set and neither rotate bit is set, the last step exchanges accumulator bits [5:0] with bits [11:6].
- R9: When bits 3 and 2 are both set, no rotation and no swap take place, whatever bit 1 is.
- R10: `rd_acc_o` is 1 when any of bits 5, 3, 2, 1 or 0 is set. `rd_lnk_o` is 1 when any of bits 4, 3, 2 or 0 is set.
- R11: `wr_acc_o` is 1 when any of bits 7, 5, 3, 2, 1 or 0 is set. `wr_lnk_o` is 1 when any of bits 6, 4, 3, 2 or 0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Field and operands are present |
| field_i | input | 9 | Operate field |
| acc_i | input | 12 | Current accumulator |
| lnk_i | input | 1 | Current link |
| res_vld_o | output | 1 | Registered results belong to an accepted field |
| acc_o | output | 12 | Registered new accumulator |
| lnk_o | output | 1 | Registered new link |
| rd_acc_o | output | 1 | Instruction consumed the accumulator |
| rd_lnk_o | output | 1 | Instruction consumed the link |
| wr_acc_o | output | 1 | Instruction produced the accumulator |
| wr_lnk_o | output | 1 | Instruction produced the link |

## Verification
Two functions can meet in one instruction: an increment whose wrap inverts the link, followed by a rotate that carries that inverted link into the accumulator. The same holds for the bit that either doubles a rotate or swaps halves, depending on the rotate bits beside it. The bench walks all 256 accepted field values with random operands. It adds directed vectors that force the wrap, a single rotate followed by a doubled one, and both rotate bits together. Each result is compared against a sequential reference model that applies the steps in the stated order.

// File: rtl/acc_opr_pkg.sv
package acc_opr_pkg;

    // bit positions inside the operate field
    localparam int FB_GROUP   = 8;
    localparam int FB_CLR_ACC = 7;
    localparam int FB_CLR_LNK = 6;
    localparam int FB_CPL_ACC = 5;
    localparam int FB_CPL_LNK = 4;
    localparam int FB_ROT_R   = 3;
    localparam int FB_ROT_L   = 2;
    localparam int FB_DBL_SWP = 1;
    localparam int FB_INC     = 0;
    localparam int FIELD_W    = 9;

    typedef struct packed {
        logic clr_acc;
        logic clr_lnk;
        logic cpl_acc;
        logic cpl_lnk;
        logic inc;
        logic rot_r;
        logic rot_l;
        logic dbl_swp;
    } micro_ops_t;

    typedef struct packed {
        logic rd_acc;
        logic rd_lnk;
        logic wr_acc;
        logic wr_lnk;
    } use_flags_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import acc_opr_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    output logic               group_o,
    output micro_ops_t         ops_o,
    output use_flags_t         use_o
);
    always_comb begin
        group_o       = ~field_i[FB_GROUP];
        ops_o.clr_acc = field_i[FB_CLR_ACC];
        ops_o.clr_lnk = field_i[FB_CLR_LNK];
        ops_o.cpl_acc = field_i[FB_CPL_ACC];
        ops_o.cpl_lnk = field_i[FB_CPL_LNK];
        ops_o.inc     = field_i[FB_INC];
        ops_o.rot_r   = field_i[FB_ROT_R];
        ops_o.rot_l   = field_i[FB_ROT_L];
        ops_o.dbl_swp = field_i[FB_DBL_SWP];

        use_o.rd_acc = ops_o.cpl_acc | ops_o.rot_r | ops_o.rot_l
                     | ops_o.dbl_swp | ops_o.inc;
        use_o.rd_lnk = ops_o.cpl_lnk | ops_o.rot_r | ops_o.rot_l | ops_o.inc;
        use_o.wr_acc = ops_o.clr_acc | ops_o.cpl_acc | ops_o.rot_r
                     | ops_o.rot_l | ops_o.dbl_swp | ops_o.inc;
        use_o.wr_lnk = ops_o.clr_lnk | ops_o.cpl_lnk | ops_o.rot_r
                     | ops_o.rot_l | ops_o.inc;
    end
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
    import acc_opr_pkg::*;
#(
    parameter int ACC_W    = 12,
    parameter int MAX_ROTS = 2
) (
    input  micro_ops_t       ops_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             lnk_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             lnk_o
);
    localparam int HALF_W = ACC_W / 2;
    localparam int RING_W = ACC_W + 1;

    logic [ACC_W-1:0]  acc_pre;
    logic              lnk_pre;
    logic [ACC_W-1:0]  acc_inc;
    logic              rot_one_dir;
    logic [RING_W-1:0] ring [MAX_ROTS+1];

    // clear, complement, then increment with link toggle on wrap
    always_comb begin
        acc_pre = ops_i.clr_acc ? '0 : acc_i;
        lnk_pre = ops_i.clr_lnk ? 1'b0 : lnk_i;
        if (ops_i.cpl_acc) acc_pre = ~acc_pre;
        if (ops_i.cpl_lnk) lnk_pre = ~lnk_pre;
        acc_inc = acc_pre + ACC_W'(1);
        if (ops_i.inc) begin
            acc_pre = acc_inc;
            if (acc_inc == '0) lnk_pre = ~lnk_pre;
        end
    end

    assign rot_one_dir = ops_i.rot_r ^ ops_i.rot_l;
    assign ring[0]     = {lnk_pre, acc_pre};

    // chain of single-step rotate stages; stage 0 runs on any single
    // direction, later stages only when doubling is requested
    for (genvar g = 0; g < MAX_ROTS; g++) begin : g_rot
        logic stage_en;
        assign stage_en = rot_one_dir & ((g == 0) | ops_i.dbl_swp);
        always_comb begin
            ring[g+1] = ring[g];
            if (stage_en) begin
                if (ops_i.rot_r) ring[g+1] = {ring[g][0], ring[g][RING_W-1:1]};
                else             ring[g+1] = {ring[g][RING_W-2:0], ring[g][RING_W-1]};
            end
        end
    end

    always_comb begin
        {lnk_o, acc_o} = ring[MAX_ROTS];
        if (ops_i.dbl_swp && !ops_i.rot_r && !ops_i.rot_l)
            acc_o = {acc_o[HALF_W-1:0], acc_o[ACC_W-1:HALF_W]};
    end
endmodule

// File: rtl/acc_opr_unit.sv
module acc_opr_unit
    import acc_opr_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vld_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic               lnk_i,
    output logic               res_vld_o,
    output logic [ACC_W-1:0]   acc_o,
    output logic               lnk_o,
    output logic               rd_acc_o,
    output logic               rd_lnk_o,
    output logic               wr_acc_o,
    output logic               wr_lnk_o
);
    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] acc;
        logic             lnk;
        use_flags_t       use_f;
    } unit_state_t;

    unit_state_t      st_d, st_q;
    logic             grp_sel;
    micro_ops_t       ops;
    use_flags_t       use_f;
    logic [ACC_W-1:0] acc_new;
    logic             lnk_new;

    opr_decode u_dec (
        .field_i (field_i),
        .group_o (grp_sel),
        .ops_o   (ops),
        .use_o   (use_f)
    );

    opr_datapath #(.ACC_W(ACC_W), .MAX_ROTS(2)) u_dp (
        .ops_i (ops),
        .acc_i (acc_i),
        .lnk_i (lnk_i),
        .acc_o (acc_new),
        .lnk_o (lnk_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (vld_i && grp_sel) begin
            st_d.vld   = 1'b1;
            st_d.acc   = acc_new;
            st_d.lnk   = lnk_new;
            st_d.use_f = use_f;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_vld_o = st_q.vld;
    assign acc_o     = st_q.acc;
    assign lnk_o     = st_q.lnk;
    assign rd_acc_o  = st_q.use_f.rd_acc;
    assign rd_lnk_o  = st_q.use_f.rd_lnk;
    assign wr_acc_o  = st_q.use_f.wr_acc;
    assign wr_lnk_o  = st_q.use_f.wr_lnk;
endmodule

// File: rtl/acc_opr_unit_chk.sv
module acc_opr_unit_chk #(
    parameter int ACC_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             vld_i,
    input logic [8:0]       field_i,
    input logic [ACC_W-1:0] acc_i,
    input logic             lnk_i,
    input logic             res_vld_o,
    input logic [ACC_W-1:0] acc_o,
    input logic             lnk_o,
    input logic             rd_acc_o,
    input logic             rd_lnk_o,
    input logic             wr_acc_o,
    input logic             wr_lnk_o
);
    logic take;
    assign take = vld_i && !field_i[8];

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_vld_o && acc_o == '0 && !lnk_o && !wr_acc_o && !rd_acc_o));

    // R2
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !take |=> (!res_vld_o && $stable(acc_o) && $stable(lnk_o) && $stable(wr_lnk_o)));

    a_r2_valid_follows_take: assert property (@(posedge clk) disable iff (rst)
        take |=> res_vld_o);

    // R3
    a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
        (take && field_i == 9'o200) |=> (acc_o == '0 && lnk_o == $past(lnk_i)));

    // R5
    a_r5_wrap_toggles_link: assert property (@(posedge clk) disable iff (rst)
        (take && field_i == 9'o001 && acc_i == '1) |=> (acc_o == '0 && lnk_o == !$past(lnk_i)));

    // R9
    a_r9_opposed_rotates_idle: assert property (@(posedge clk) disable iff (rst)
        (take && field_i == 9'o016) |=> (acc_o == $past(acc_i) && lnk_o == $past(lnk_i)));

    // R11
    a_r11_empty_field_writes_nothing: assert property (@(posedge clk) disable iff (rst)
        (take && field_i == 9'o000) |=> (!wr_acc_o && !wr_lnk_o && !rd_acc_o && !rd_lnk_o));
endmodule

bind acc_opr_unit acc_opr_unit_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (vld_i),
    .field_i   (field_i),
    .acc_i     (acc_i),
    .lnk_i     (lnk_i),
    .res_vld_o (res_vld_o),
    .acc_o     (acc_o),
    .lnk_o     (lnk_o),
    .rd_acc_o  (rd_acc_o),
    .rd_lnk_o  (rd_lnk_o),
    .wr_acc_o  (wr_acc_o),
    .wr_lnk_o  (wr_lnk_o)
);

// File: tb/acc_opr_unit_tb.sv
module acc_opr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [8:0]  field_i = '0;
    logic [11:0] acc_i = '0;
    logic        lnk_i = 1'b0;
    logic        res_vld_o, lnk_o, rd_acc_o, rd_lnk_o, wr_acc_o, wr_lnk_o;
    logic [11:0] acc_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic        done = 1'b0;
    logic [11:0] last_acc = '0;
    logic        last_lnk = 1'b0;

    typedef struct {
        logic [8:0]  f;
        logic [11:0] acc;
        logic        lnk;
        logic [3:0]  flg;   // rd_acc, rd_lnk, wr_acc, wr_lnk
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    acc_opr_unit u_dut (
        .clk(clk), .rst(rst), .vld_i(vld_i), .field_i(field_i),
        .acc_i(acc_i), .lnk_i(lnk_i), .res_vld_o(res_vld_o),
        .acc_o(acc_o), .lnk_o(lnk_o), .rd_acc_o(rd_acc_o),
        .rd_lnk_o(rd_lnk_o), .wr_acc_o(wr_acc_o), .wr_lnk_o(wr_lnk_o)
    );

    function automatic exp_t model(logic [8:0] f, logic [11:0] a, logic l);
        exp_t e;
        logic [12:0] x;
        int reps;
        if (f[7]) a = '0;
        if (f[6]) l = 1'b0;
        if (f[5]) a = ~a;
        if (f[4]) l = ~l;
        if (f[0]) begin
            a = a + 12'd1;
            if (a == 12'd0) l = ~l;
        end
        reps = f[1] ? 2 : 1;
        if (f[3] != f[2]) begin
            for (int i = 0; i < reps; i++) begin
                x = {l, a};
                if (f[3]) x = {x[0], x[12:1]};
                else      x = {x[11:0], x[12]};
                l = x[12];
                a = x[11:0];
            end
        end
        if (f[1] && !f[3] && !f[2]) a = {a[5:0], a[11:6]};
        e.f   = f;
        e.acc = a;
        e.lnk = l;
        e.flg = {f[5] | f[3] | f[2] | f[1] | f[0],
                 f[4] | f[3] | f[2] | f[0],
                 f[7] | f[5] | f[3] | f[2] | f[1] | f[0],
                 f[6] | f[4] | f[3] | f[2] | f[0]};
        return e;
    endfunction

    function automatic string tag_of(logic [8:0] f);
        if (f[3] && f[2])        return "R9";
        if ((f[3] | f[2]) && f[1]) return "R7";
        if (f[3] | f[2])         return "R6";
        if (f[1])                return "R8";
        if (f[0])                return "R5";
        if (f[5] | f[4])         return "R4";
        if (f[7] | f[6])         return "R3";
        return "R2";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [8:0] f, logic [11:0] a, logic l);
        @(negedge clk);
        vld_i   = 1'b1;
        field_i = f;
        acc_i   = a;
        lnk_i   = l;
        if (!f[8]) sb.push_back(model(f, a, l));
    endtask

    task automatic idle();
        @(negedge clk);
        vld_i = 1'b0;
        field_i = $urandom;
        acc_i = $urandom;
        lnk_i = $urandom;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) idle();
    endtask

    // monitor: pops expected items when results appear
    always @(posedge clk) begin
        #2;
        if (!rst && res_vld_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected res_vld_o", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(acc_o == e.acc && lnk_o == e.lnk, tag_of(e.f),
                      $sformatf("field %o {lnk,acc}", e.f),
                      int'({lnk_o, acc_o}), int'({e.lnk, e.acc}));
                check({rd_acc_o, rd_lnk_o} == e.flg[3:2], "R10",
                      $sformatf("field %o read flags", e.f),
                      int'({rd_acc_o, rd_lnk_o}), int'(e.flg[3:2]));
                check({wr_acc_o, wr_lnk_o} == e.flg[1:0], "R11",
                      $sformatf("field %o write flags", e.f),
                      int'({wr_acc_o, wr_lnk_o}), int'(e.flg[1:0]));
                last_acc = e.acc;
                last_lnk = e.lnk;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk); #2;
        check(!res_vld_o && acc_o == 12'd0 && !lnk_o && !wr_acc_o && !wr_lnk_o
              && !rd_acc_o && !rd_lnk_o, "R1", "reset state",
              int'({res_vld_o, lnk_o, acc_o}), 0);
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        apply(9'o001, 12'hFFF, 1'b0);   // R5 wrap sets link from 0
        apply(9'o001, 12'hFFF, 1'b1);   // R5 wrap clears link from 1
        apply(9'o041, 12'h000, 1'b0);   // R4 then R5: complement then wrap
        apply(9'o010, 12'h001, 1'b0);   // R6 right
        apply(9'o004, 12'h800, 1'b0);   // R6 left
        apply(9'o012, 12'h001, 1'b0);   // R7 double right
        apply(9'o006, 12'h801, 1'b1);   // R7 double left
        apply(9'o002, 12'o1234, 1'b0);  // R8 swap
        apply(9'o016, 12'hA5C, 1'b1);   // R9 both rotates with swap bit
        apply(9'o014, 12'h3C3, 1'b0);   // R9 both rotates
        apply(9'o011, 12'hFFF, 1'b0);   // R5 wrap feeds R6 rotate
        apply(9'o300, 12'h123, 1'b1);   // R3 clear both
        apply(9'o377, 12'h555, 1'b1);   // everything at once
        drain();

        // R2: field with group bit set is ignored while vld_i is high
        @(negedge clk);
        vld_i = 1'b1; field_i = 9'o600; acc_i = 12'h777; lnk_i = ~last_lnk;
        @(posedge clk); #2;
        check(!res_vld_o && acc_o == last_acc && lnk_o == last_lnk, "R2",
              "group bit set ignored", int'({res_vld_o, lnk_o, acc_o}),
              int'({1'b0, last_lnk, last_acc}));
        idle();
        @(posedge clk); #2;
        check(!res_vld_o && acc_o == last_acc && lnk_o == last_lnk, "R2",
              "idle hold", int'({res_vld_o, lnk_o, acc_o}),
              int'({1'b0, last_lnk, last_acc}));

        // all 256 accepted fields, back to back, random operands
        for (int f = 0; f < 256; f++) apply(9'(f), 12'($urandom), 1'($urandom));
        // second pass interleaving ignored fields and idles
        for (int f = 0; f < 256; f++) begin
            apply(9'(f), 12'($urandom), 1'($urandom));
            if (f % 5 == 0) apply(9'(9'o400 | f), 12'($urandom), 1'($urandom));
            if (f % 7 == 0) idle();
        end
        drain();
        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);

        // R1: reset in the middle of operation
        apply(9'o040, 12'h0F0, 1'b1);
        @(negedge clk);
        vld_i = 1'b0;
        rst   = 1'b1;
        @(posedge clk); #2;
        check(!res_vld_o && acc_o == 12'd0 && !lnk_o && !wr_acc_o && !rd_acc_o,
              "R1", "mid-run reset", int'({res_vld_o, lnk_o, acc_o}), 0);
        sb.delete();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule